// File: doc/BRIEF.md
# Two-Channel Serial Controller Register Access Unit

This block is the host-facing register file of a two-channel serial communications controller. The host sees only four byte-wide locations: a control port and a data port for each of the two channels. The sixteen write registers and sixteen read registers of a channel are reached through that channel's control port. The first control write loads a register pointer and may also carry a command. The next control access reads or writes the register the pointer selects, after which the pointer falls back to zero.

Channel resets are issued by writing a code to register 9. A soft reset and a hard reset both change the channel configuration, but each keeps a different set of bits. The block also turns each channel's time-constant and clock-mode settings into a bit-rate figure. It exposes the enable bits that the serial shifters need. It gives one-cycle pulses when a data port is written or read. The received byte of each channel comes in as an input and is returned on a data-port read.

Top module: `dual_chan_regfile`

## Requirements
- R1: After power-on reset every write register is zero. Status read register 0 reads 0x04 (transmit buffer empty) and every other read register reads 0. Both pointers are 0.
- R2: With SWAP_ADDR=0, addr[0] selects the data port (1) or the control port (0), and addr[1] selects channel A (0) or B (1). SWAP_ADDR=1 swaps the roles of the two bits.
- R3: A control write made while the channel pointer is 0 loads wdata[2:0] into the pointer. If wdata[5:3] is 001, pointer bit 3 is also set. No other command code changes the pointer or any register.
- R4: A control read returns the read register the pointer selects: 0 is status, 1 is special status, 2 to 8 read 0, and 9 to 15 return the write register of the same number. A control read, or a control write while the pointer is non-zero, returns the pointer to 0.
- R5: Writing register 3 with bit 4 set also sets bit 4 (hunt) of status register 0. Other status bits are unaffected.
- R6: When a write to register 9 has wdata[7:6] non-zero, the value is not stored. Code 01 soft-resets channel B, 10 soft-resets channel A, and 11 hard-resets both channels. Every channel that is reset, and the accessing channel, ends with pointer 0.
- R7: A soft reset does the following in a single cycle.
  - Write registers: clears register 0 and sets register 15 to 0xF8. Register 1 keeps bits 5 and 2. Register 3 clears bit 0. Register 4 sets bit 2. Register 5 keeps bits 6, 5 and 0. Register 9 clears bit 5. Register 10 keeps bits 6:5. Register 14 keeps bits 7:6 and 1:0 and sets bit 5.
  - Read registers: status keeps bits 7, 5, 4 and 3 and sets bits 6 and 2. Special status keeps bit 0 and sets bits 2:1.
- R8: A hard reset applies the soft reset to both channels. It then sets register 9 to (old & 0x03) | 0xC0, register 10 to 0, register 11 to 0x08, and register 14 to (old & 0xC0) | 0x30.
- R9: rate_a and rate_b equal CLK_HZ / ({reg13, reg12} + 2), shifted right by 0, 4, 5 or 6 as that channel's register 4 bits 7:6 are 00, 01, 10 or 11.
- R10: A data-port write raises data_wr[ch] for exactly the following cycle, with tx_byte holding the written byte. A data-port read returns that channel's rx input in the same cycle and raises data_rd[ch] for the following cycle. Index 0 is channel A.
- R11: rx_en, tx_en and loopback of each channel follow register 3 bit 0, register 5 bit 3 and register 14 bit 4 of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 2 | Port and channel select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| rx_a | input | 8 | Received byte of channel A |
| rx_b | input | 8 | Received byte of channel B |
| tx_byte | output | 8 | Last byte written to a data port |
| data_wr | output | 2 | Data-port write pulse per channel |
| data_rd | output | 2 | Data-port read pulse per channel |
| rx_en | output | 2 | Receiver enable per channel |
| tx_en | output | 2 | Transmitter enable per channel |
| loopback | output | 2 | Local loopback per channel |
| rate_a | output | RATE_W | Bit rate of channel A |
| rate_b | output | RATE_W | Bit rate of channel B |

## Verification
The hardest state to reach is a reset issued through one channel that hits the other channel, or both. Just before it, the target registers must hold values the reset masks would visibly alter, and the accessing channel's own register 9 must hold a value that a wrongly stored reset code would overwrite. Directed sequences first load such values, then issue codes 01 and 11 from the opposite channel and read every affected register back through the pointer. A seeded random stream of pointer writes, register reads and data accesses then mixes occasional reset codes with arbitrary register contents. Its results are compared with a model built from the requirements.

// File: rtl/dual_chan_regfile.sv
module dual_chan_regfile #(
  parameter int unsigned CLK_HZ    = 4915200,
  parameter int unsigned RATE_W    = 32,
  parameter bit          SWAP_ADDR = 1'b0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [7:0]        rx_a,
  input  logic [7:0]        rx_b,
  output logic [7:0]        tx_byte,
  output logic [1:0]        data_wr,
  output logic [1:0]        data_rd,
  output logic [1:0]        rx_en,
  output logic [1:0]        tx_en,
  output logic [1:0]        loopback,
  output logic [RATE_W-1:0] rate_a,
  output logic [RATE_W-1:0] rate_b
);
  localparam int NREG = 16;
  localparam int PW   = $clog2(NREG);

  logic [7:0]        wreg [2][NREG];
  logic [7:0]        stat [2];
  logic [7:0]        spec [2];
  logic [PW-1:0]     ptr  [2];
  logic [RATE_W-1:0] rate_v [2];

  logic ch, dsel;
  assign ch   = SWAP_ADDR ? addr[0] : addr[1];
  assign dsel = SWAP_ADDR ? addr[1] : addr[0];

  logic w_ctl, w_dat, r_ctl, r_dat;
  assign w_ctl = cs & wr & ~dsel;
  assign w_dat = cs & wr & dsel;
  assign r_ctl = cs & rd & ~wr & ~dsel;
  assign r_dat = cs & rd & ~wr & dsel;

  logic [PW-1:0] cur;
  assign cur = ptr[ch];

  logic [1:0] rst_sel;
  logic       rst_req, hard;
  assign rst_sel = {wdata[6], wdata[7]};
  assign hard    = &wdata[7:6];
  assign rst_req = (cur == 4'd9) && (|wdata[7:6]);

  always_comb begin
    rdata = 8'h00;
    if (dsel)             rdata = ch ? rx_b : rx_a;
    else if (cur == 4'd0) rdata = stat[ch];
    else if (cur == 4'd1) rdata = spec[ch];
    else if (cur >= 4'd9) rdata = wreg[ch][cur];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        for (int r = 0; r < NREG; r++) wreg[c][r] <= 8'h00;
        stat[c] <= 8'h04;
        spec[c] <= 8'h00;
        ptr[c]  <= '0;
      end
      tx_byte <= 8'h00;
      data_wr <= 2'b00;
      data_rd <= 2'b00;
    end else begin
      data_wr <= {w_dat & ch, w_dat & ~ch};
      data_rd <= {r_dat & ch, r_dat & ~ch};
      if (w_dat) tx_byte <= wdata;
      if (r_ctl) ptr[ch] <= '0;
      if (w_ctl) begin
        if (cur == 4'd0) begin
          ptr[ch] <= {wdata[5:3] == 3'b001, wdata[2:0]};
        end else begin
          ptr[ch] <= '0;
          if (rst_req) begin
            for (int c = 0; c < 2; c++) begin
              if (rst_sel[c]) begin
                ptr[c]      <= '0;
                wreg[c][0]  <= 8'h00;
                wreg[c][1]  <= wreg[c][1] & 8'h24;
                wreg[c][3]  <= wreg[c][3] & 8'hFE;
                wreg[c][4]  <= wreg[c][4] | 8'h04;
                wreg[c][5]  <= wreg[c][5] & 8'h61;
                wreg[c][9]  <= wreg[c][9] & 8'hDF;
                wreg[c][10] <= wreg[c][10] & 8'h60;
                wreg[c][14] <= (wreg[c][14] & 8'hC3) | 8'h20;
                wreg[c][15] <= 8'hF8;
                stat[c]     <= (stat[c] & 8'hB8) | 8'h44;
                spec[c]     <= (spec[c] & 8'h01) | 8'h06;
                if (hard) begin
                  wreg[c][9]  <= (wreg[c][9] & 8'h03) | 8'hC0;
                  wreg[c][10] <= 8'h00;
                  wreg[c][11] <= 8'h08;
                  wreg[c][14] <= (wreg[c][14] & 8'hC0) | 8'h30;
                end
              end
            end
          end else begin
            wreg[ch][cur] <= wdata;
            if (cur == 4'd3 && wdata[4]) stat[ch] <= stat[ch] | 8'h10;
          end
        end
      end
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [15:0] tc;
    logic [31:0] quot;
    logic [1:0]  mode;
    logic [2:0]  sh;
    assign tc   = {wreg[c][13], wreg[c][12]};
    assign quot = CLK_HZ / ({16'd0, tc} + 32'd2);
    assign mode = wreg[c][4][7:6];
    assign sh   = (mode == 2'd0) ? 3'd0 : ({1'b0, mode} + 3'd3);
    assign rate_v[c]   = RATE_W'(quot >> sh);
    assign rx_en[c]    = wreg[c][3][0];
    assign tx_en[c]    = wreg[c][5][3];
    assign loopback[c] = wreg[c][14][4];

    // R4
    ptr_idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (r_ctl && ch == 1'(c)) |=> ptr[c] == '0);
    // R5
    hunt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ctl && ch == 1'(c) && cur == 4'd3 && wdata[4]) |=> stat[c][4]);
    // R6
    rst_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ctl && rst_req && !rst_sel[c]) |=> $stable(wreg[c][9]));
    // R8
    hard_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ctl && rst_req && hard) |=> (wreg[c][11] == 8'h08 && wreg[c][10] == 8'h00));
    // R7
    txe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) stat[c][2]);
    // R10
    wr_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr[c] |-> $past(w_dat && ch == 1'(c)));
  end

  assign rate_a = rate_v[0];
  assign rate_b = rate_v[1];
endmodule

// File: tb/dual_chan_regfile_test.sv
module dual_chan_regfile_test;
  localparam int unsigned CLK_HZ = 4915200;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0]  addr = 2'b00;
  logic [7:0]  wdata = 8'h00, rx_a = 8'h5A, rx_b = 8'hC3;
  logic [7:0]  rdata, tx_byte;
  logic [1:0]  data_wr, data_rd, rx_en, tx_en, loopback;
  logic [31:0] rate_a, rate_b;

  dual_chan_regfile #(.CLK_HZ(CLK_HZ), .RATE_W(32), .SWAP_ADDR(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_a(rx_a), .rx_b(rx_b), .tx_byte(tx_byte),
    .data_wr(data_wr), .data_rd(data_rd), .rx_en(rx_en), .tx_en(tx_en),
    .loopback(loopback), .rate_a(rate_a), .rate_b(rate_b));

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [7:0] m_wr [2][16];
  logic [7:0] m_st [2];
  logic [7:0] m_sp [2];
  logic [3:0] m_ptr [2];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic m_init();
    for (int c = 0; c < 2; c++) begin
      for (int r = 0; r < 16; r++) m_wr[c][r] = 8'h00;
      m_st[c] = 8'h04; m_sp[c] = 8'h00; m_ptr[c] = 4'd0;
    end
  endtask

  task automatic m_soft(input int c);
    m_ptr[c] = 4'd0;
    m_wr[c][0] = 8'h00;
    m_wr[c][1] &= 8'h24;
    m_wr[c][3] &= 8'hFE;
    m_wr[c][4] |= 8'h04;
    m_wr[c][5] &= 8'h61;
    m_wr[c][9] &= 8'hDF;
    m_wr[c][10] &= 8'h60;
    m_wr[c][14] = (m_wr[c][14] & 8'hC3) | 8'h20;
    m_wr[c][15] = 8'hF8;
    m_st[c] = (m_st[c] & 8'hB8) | 8'h44;
    m_sp[c] = (m_sp[c] & 8'h01) | 8'h06;
  endtask

  task automatic m_hard(input int c);
    m_wr[c][9]  = (m_wr[c][9] & 8'h03) | 8'hC0;
    m_wr[c][10] = 8'h00;
    m_wr[c][11] = 8'h08;
    m_wr[c][14] = (m_wr[c][14] & 8'hC0) | 8'h30;
  endtask

  task automatic m_ctrl(input int c, input logic [7:0] v);
    int n;
    if (m_ptr[c] == 4'd0) begin
      m_ptr[c] = {v[5:3] == 3'b001, v[2:0]};
    end else begin
      n = int'(m_ptr[c]);
      m_ptr[c] = 4'd0;
      if (n == 9 && v[7:6] != 2'b00) begin
        if (v[7]) m_soft(0);
        if (v[6]) m_soft(1);
        if (v[7:6] == 2'b11) begin m_hard(0); m_hard(1); end
      end else begin
        m_wr[c][n] = v;
        if (n == 3 && v[4]) m_st[c] |= 8'h10;
      end
    end
  endtask

  function automatic logic [7:0] exp_rd(input int c, input int n);
    if (n == 0) return m_st[c];
    if (n == 1) return m_sp[c];
    if (n >= 9) return m_wr[c][n];
    return 8'h00;
  endfunction

  function automatic logic [31:0] exp_rate(input int c);
    logic [31:0] q;
    q = CLK_HZ / ({16'd0, m_wr[c][13], m_wr[c][12]} + 32'd2);
    case (m_wr[c][4][7:6])
      2'd0: return q;
      2'd1: return q >> 4;
      2'd2: return q >> 5;
      default: return q >> 6;
    endcase
  endfunction

  function automatic logic [7:0] sel_cmd(input int n);
    return 8'(n & 7) | ((n >= 8) ? 8'h08 : 8'h00);
  endfunction

  task automatic bus_wr(input bit c, input bit d, input logic [7:0] v);
    @(negedge clk); cs = 1; wr = 1; addr = {c, d}; wdata = v;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(input bit c, input bit d, output logic [7:0] v);
    @(negedge clk); cs = 1; rd = 1; addr = {c, d};
    #1 v = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic ctrl_wr(input int c, input logic [7:0] v);
    bus_wr(c[0], 1'b0, v); m_ctrl(c, v);
  endtask

  task automatic reg_write(input int c, input int n, input logic [7:0] v);
    ctrl_wr(c, sel_cmd(n)); ctrl_wr(c, v);
  endtask

  task automatic reg_check(input string tag, input int c, input int n);
    logic [7:0] v;
    if (n != 0) ctrl_wr(c, sel_cmd(n));
    bus_rd(c[0], 1'b0, v);
    check($sformatf("%s ch%0d rr%0d", tag, c, n), {24'd0, v}, {24'd0, exp_rd(c, n)});
    m_ptr[c] = 4'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h1BADF00D));
    m_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents through the pointer
    for (int c = 0; c < 2; c++)
      for (int n = 0; n < 16; n++) reg_check("R1", c, n);
    check("R1 rx_en", {30'd0, rx_en}, 32'd0);
    check("R1 rate_a", rate_a, CLK_HZ / 2);

    // R3 R4: high pointer via command 001, then auto-return to 0
    reg_write(0, 12, 8'h34);
    reg_check("R3 R4 mirror", 0, 12);
    bus_rd(1'b0, 1'b0, v);
    check("R4 ptr back to status", {24'd0, v}, 32'h04);
    ctrl_wr(0, 8'h21);  // command 100 does not set pointer bit 3
    bus_rd(1'b0, 1'b0, v);
    check("R3 non-high cmd", {24'd0, v}, {24'd0, m_sp[0]});
    m_ptr[0] = 4'd0;

    // R5 R11: hunt bit and receiver enable on channel B
    reg_write(1, 3, 8'h11);
    reg_check("R5 hunt", 1, 0);
    check("R11 rx_en", {30'd0, rx_en}, 32'h2);
    reg_write(0, 5, 8'h08);
    check("R11 tx_en", {30'd0, tx_en}, 32'h1);

    // R9: all four clock modes, tc = 10
    reg_write(0, 12, 8'd10);
    reg_write(0, 13, 8'd0);
    for (int m = 0; m < 4; m++) begin
      reg_write(0, 4, 8'(m << 6));
      check($sformatf("R9 mode %0d", m), rate_a, exp_rate(0));
    end
    check("R9 literal", rate_a, 32'd6400);

    // R6 R7: soft reset of B issued from A
    reg_write(0, 9, 8'h21);
    reg_write(0, 3, 8'h01);
    reg_write(1, 15, 8'h00);
    reg_write(1, 5, 8'h68);
    reg_write(1, 14, 8'hFF);
    reg_write(0, 9, 8'h40);
    check("R6 ch A untouched", {30'd0, rx_en}, 32'h1);
    check("R7 tx_en B cleared", {30'd0, tx_en}, 32'h1);
    reg_check("R6 no store", 0, 9);
    check("R6 model wr9", {24'd0, m_wr[0][9]}, 32'h21);
    reg_check("R7 wr15", 1, 15);
    reg_check("R7 wr14", 1, 14);
    reg_check("R7 status", 1, 0);
    reg_check("R7 special", 1, 1);

    // R8: hard reset from B
    reg_write(0, 14, 8'h0F);
    reg_write(0, 11, 8'h55);
    reg_write(1, 9, 8'hC0);
    check("R8 loopback", {30'd0, loopback}, 32'h3);
    for (int c = 0; c < 2; c++) begin
      reg_check("R8", c, 9);
      reg_check("R8", c, 10);
      reg_check("R8", c, 11);
      reg_check("R8", c, 14);
      reg_check("R8", c, 15);
    end
    check("R8 wr9 A", {24'd0, m_wr[0][9]}, 32'hC1);

    // R10 R2: data ports
    bus_wr(1'b1, 1'b1, 8'hA7);
    check("R10 data_wr", {30'd0, data_wr}, 32'h2);
    check("R10 tx_byte", {24'd0, tx_byte}, 32'hA7);
    @(negedge clk);
    check("R10 pulse width", {30'd0, data_wr}, 32'h0);
    bus_rd(1'b0, 1'b1, v);
    check("R2 R10 data read A", {24'd0, v}, {24'd0, rx_a});
    check("R10 data_rd", {30'd0, data_rd}, 32'h1);
    bus_rd(1'b1, 1'b1, v);
    check("R2 R10 data read B", {24'd0, v}, {24'd0, rx_b});
    reg_check("R2 data read leaves pointer", 1, 0);

    // random mix
    for (int i = 0; i < 500; i++) begin
      int c, op, n;
      logic [7:0] r;
      c = int'($urandom_range(1, 0));
      op = int'($urandom_range(9, 0));
      r = 8'($urandom);
      if (op <= 3) begin
        n = int'($urandom_range(15, 1));
        if (n == 9 && $urandom_range(7, 0) != 0) r[7:6] = 2'b00;
        reg_write(c, n, r);
      end else if (op <= 6) begin
        reg_check("R4 random", c, int'($urandom_range(15, 0)));
      end else if (op == 7) begin
        bus_wr(c[0], 1'b1, r);
        check("R10 random wr", {30'd0, data_wr}, (c == 1) ? 32'h2 : 32'h1);
        check("R10 random byte", {24'd0, tx_byte}, {24'd0, r});
      end else if (op == 8) begin
        rx_a = r; rx_b = ~r;
        bus_rd(c[0], 1'b1, v);
        check("R10 random rd", {24'd0, v}, (c == 1) ? {24'd0, ~r} : {24'd0, r});
      end else begin
        check("R9 random A", rate_a, exp_rate(0));
        check("R9 random B", rate_b, exp_rate(1));
        check("R11 random loop", {30'd0, loopback}, {30'd0, m_wr[1][14][4], m_wr[0][14][4]});
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule